// File: doc/BRIEF.md
# Timer Compare and Soft-Interrupt Unit

This block is a per-strand privileged register unit. It holds a free-running 63-bit tick counter, two compare channels (supervisor and hypervisor) and a software interrupt register. When the counter steps onto an armed compare value, the supervisor channel sets a sticky bit in the software interrupt register and the hypervisor channel sets a pending register. Each channel also emits a one-cycle interrupt request pulse.

Software reaches the unit through one register port that selects a register by a 4-bit index. The software interrupt register can be written three ways: a direct write that replaces it, a set alias that ORs bits in, and a clear alias that removes bits. Three more registers have fixed side effects. The hypervisor trap base register always reads with its low 15 bits at zero. The version register is read-only and returns build-time limits. The hypervisor state register always reads with its identification bit set.

Reads are registered: `rd_data` shows the selected register one cycle after `rd_en`, and holds its value between reads. An access to an index that does not exist, or a write to a read-only register, is reported by a one-cycle `illegal_acc` pulse.

Top module: `tmr_softint_unit`

## Requirements
- R1: The tick counter (index 3, read-only, read as {1'b0, count}) resets to 0, adds 1 at every clock edge where `cnt_en` is 1, holds otherwise, and wraps modulo 2^63.
- R2: Compare registers (supervisor at index 4, hypervisor at index 5) reset to 0x8000_0000_0000_0000; bit 63 is a disable flag, bits 62:0 the compare value, and a read returns the last value written.
- R3: At a clock edge where the counter steps from V-1 to V, and the supervisor compare holds V with bit 63 clear, bit 16 of the soft-interrupt register (index 0) becomes 1 and `soft_irq` is 1 for exactly the following cycle.
- R4: Under the same condition on the hypervisor compare, the pending register (index 6) becomes 1 and `hyp_tmr_irq` is 1 for exactly the following cycle.
- R5: A match occurs only by the counter stepping onto the value: a compare value at or behind the held count, or one with bit 63 set, raises no request and leaves the soft-interrupt and pending registers unchanged.
- R6: A write to index 0 replaces the soft-interrupt register and raises no request.
- R7: A write to index 1 ORs the data into the soft-interrupt register and pulses `soft_irq` in the next cycle; a write to index 2 clears the bits set in the data and raises no request.
- R8: When a match and a software write to its target register meet at the same edge, the write is applied first and the match bit is then set on top of it.
- R9: The hypervisor trap base register (index 7) stores written data with bits 14:0 forced to zero, and reads return bits 14:0 as zero.
- R10: The version register (index 8) reads as {40'b0, MAX_GL[7:0], MAX_TL[7:0], NWIN[7:0]} (0x030608 by default); a write to it changes nothing and pulses `illegal_acc`.
- R11: The hypervisor state register (index 9) resets to 0x800 and stores every write with bit 11 forced to 1.
- R12: Indices 10 to 15 read as zero, ignore writes, and pulse `illegal_acc` for one cycle; a write to index 3 is ignored and also pulses it.
- R13: After reset `rd_data` is 0 and all request outputs are 0; `rd_data` updates one cycle after each `rd_en` and holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter advance enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_idx | input | 4 | Register index |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Registered read data |
| soft_irq | output | 1 | Soft-interrupt request pulse |
| hyp_tmr_irq | output | 1 | Hypervisor timer-match request pulse |
| illegal_acc | output | 1 | Illegal access pulse |

## Verification
The compare match and a software write to the same target register can land on one clock edge. The bench arms the supervisor compare two counts ahead, enables counting, and times a clear-alias write so that it meets the edge where the counter steps onto the compare value. It then reads back the soft-interrupt register and expects the cleared bits gone but bit 16 set. The hypervisor side is provoked the same way with a direct write of zero to the pending register, which must still read as 1.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

  localparam int DATA_W = 64;
  localparam int CNT_W  = DATA_W - 1;
  localparam int IDX_W  = 4;
  localparam int NUM_CMP = 2;

  typedef enum logic [IDX_W-1:0] {
    IX_SOFT     = 4'd0,
    IX_SOFT_SET = 4'd1,
    IX_SOFT_CLR = 4'd2,
    IX_TICK     = 4'd3,
    IX_SCMP     = 4'd4,
    IX_HCMP     = 4'd5,
    IX_HPEND    = 4'd6,
    IX_HTBASE   = 4'd7,
    IX_HVER     = 4'd8,
    IX_HSTATE   = 4'd9
  } reg_idx_e;

  localparam logic [DATA_W-1:0] CMP_RST = {1'b1, {CNT_W{1'b0}}};

  // Match happens when the counter is stepping onto the armed compare value.
  function automatic logic f_step_hit(input logic [CNT_W-1:0] cnt,
                                      input logic [DATA_W-1:0] cmp,
                                      input logic en);
    logic [CNT_W-1:0] nxt;
    nxt = cnt + CNT_W'(1);
    return en && !cmp[DATA_W-1] && (nxt == cmp[CNT_W-1:0]);
  endfunction

  function automatic logic [DATA_W-1:0] f_softint_next(
      input logic [DATA_W-1:0] cur,
      input logic [DATA_W-1:0] wdata,
      input logic we_dir, input logic we_set, input logic we_clr,
      input logic hit, input logic [DATA_W-1:0] hit_mask);
    logic [DATA_W-1:0] v;
    v = cur;
    if (we_dir)      v = wdata;
    else if (we_set) v = cur | wdata;
    else if (we_clr) v = cur & ~wdata;
    if (hit) v = v | hit_mask;
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] f_base_mask(input logic [DATA_W-1:0] v);
    return {v[DATA_W-1:15], 15'd0};
  endfunction

  function automatic logic [DATA_W-1:0] f_ver_word(input int nwin, input int tl, input int gl);
    return {40'd0, 8'(gl), 8'(tl), 8'(nwin)};
  endfunction

  function automatic logic f_rd_legal(input logic [IDX_W-1:0] idx);
    return idx <= IX_HSTATE;
  endfunction

  function automatic logic f_wr_legal(input logic [IDX_W-1:0] idx);
    return (idx <= IX_HSTATE) && (idx != IX_TICK) && (idx != IX_HVER);
  endfunction

endpackage

// File: rtl/tcu_tick_counter.sv
module tcu_tick_counter import tcu_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  output logic [CNT_W-1:0] cnt_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/tcu_cmp_chan.sv
module tcu_cmp_chan import tcu_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              cnt_en,
  output logic [DATA_W-1:0] cmp_q,
  output logic              hit
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmp_q <= CMP_RST;
    else if (wr_sel) cmp_q <= wr_data;
  end

  // Evaluated against the register before any same-edge write lands.
  assign hit = f_step_hit(cnt_q, cmp_q, cnt_en);

endmodule

// File: rtl/tcu_softint_reg.sv
module tcu_softint_reg import tcu_pkg::*; #(
  parameter int HIT_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_dir,
  input  logic              we_set,
  input  logic              we_clr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sup_hit,
  output logic [DATA_W-1:0] softint_q
);

  localparam logic [DATA_W-1:0] HIT_MASK = DATA_W'(1) << HIT_BIT;

  logic [DATA_W-1:0] softint_d;

  always_comb begin
    softint_d = f_softint_next(softint_q, wr_data, we_dir, we_set, we_clr,
                               sup_hit, HIT_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) softint_q <= '0;
    else        softint_q <= softint_d;
  end

endmodule

// File: rtl/tcu_hyp_regs.sv
module tcu_hyp_regs import tcu_pkg::*; #(
  parameter int ID_BIT = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_pend,
  input  logic              we_base,
  input  logic              we_state,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hyp_hit,
  output logic [DATA_W-1:0] hintp_q,
  output logic [DATA_W-1:0] htba_q,
  output logic [DATA_W-1:0] hstate_q
);

  localparam logic [DATA_W-1:0] ID_MASK = DATA_W'(1) << ID_BIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hintp_q  <= '0;
      htba_q   <= '0;
      hstate_q <= ID_MASK;
    end else begin
      if (hyp_hit)      hintp_q <= DATA_W'(1);
      else if (we_pend) hintp_q <= wr_data;
      if (we_base)  htba_q   <= f_base_mask(wr_data);
      if (we_state) hstate_q <= wr_data | ID_MASK;
    end
  end

endmodule

// File: rtl/tmr_softint_unit.sv
module tmr_softint_unit import tcu_pkg::*; #(
  parameter int NWIN       = 8,
  parameter int MAX_TL     = 6,
  parameter int MAX_GL     = 3,
  parameter int SOFT_BIT   = 16,
  parameter int HPS_ID_BIT = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              soft_irq,
  output logic              hyp_tmr_irq,
  output logic              illegal_acc
);

  localparam logic [DATA_W-1:0] VER_WORD = f_ver_word(NWIN, MAX_TL, MAX_GL);

  logic [CNT_W-1:0]   cnt_q;
  logic [DATA_W-1:0]  cmp_q [NUM_CMP];
  logic [NUM_CMP-1:0] cmp_hit;
  logic               sup_hit, hyp_hit;
  logic               wr_ok, set_wr, bad_acc;
  logic [DATA_W-1:0]  softint_q, hintp_q, htba_q, hstate_q;
  logic [DATA_W-1:0]  rd_word;

  assign wr_ok   = wr_en && f_wr_legal(reg_idx);
  assign set_wr  = wr_ok && (reg_idx == IX_SOFT_SET);
  assign bad_acc = (wr_en && !f_wr_legal(reg_idx)) || (rd_en && !f_rd_legal(reg_idx));

  tcu_tick_counter u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_en (cnt_en),
    .cnt_q  (cnt_q)
  );

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    tcu_cmp_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_sel  (wr_ok && (reg_idx == IDX_W'(int'(IX_SCMP) + g))),
      .wr_data (wr_data),
      .cnt_q   (cnt_q),
      .cnt_en  (cnt_en),
      .cmp_q   (cmp_q[g]),
      .hit     (cmp_hit[g])
    );
  end

  assign sup_hit = cmp_hit[0];
  assign hyp_hit = cmp_hit[1];

  tcu_softint_reg #(.HIT_BIT(SOFT_BIT)) u_soft (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_dir    (wr_ok && (reg_idx == IX_SOFT)),
    .we_set    (set_wr),
    .we_clr    (wr_ok && (reg_idx == IX_SOFT_CLR)),
    .wr_data   (wr_data),
    .sup_hit   (sup_hit),
    .softint_q (softint_q)
  );

  tcu_hyp_regs #(.ID_BIT(HPS_ID_BIT)) u_hyp (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_pend  (wr_ok && (reg_idx == IX_HPEND)),
    .we_base  (wr_ok && (reg_idx == IX_HTBASE)),
    .we_state (wr_ok && (reg_idx == IX_HSTATE)),
    .wr_data  (wr_data),
    .hyp_hit  (hyp_hit),
    .hintp_q  (hintp_q),
    .htba_q   (htba_q),
    .hstate_q (hstate_q)
  );

  always_comb begin
    rd_word = '0;
    case (reg_idx)
      IX_SOFT, IX_SOFT_SET, IX_SOFT_CLR: rd_word = softint_q;
      IX_TICK:   rd_word = {1'b0, cnt_q};
      IX_SCMP:   rd_word = cmp_q[0];
      IX_HCMP:   rd_word = cmp_q[1];
      IX_HPEND:  rd_word = hintp_q;
      IX_HTBASE: rd_word = f_base_mask(htba_q);
      IX_HVER:   rd_word = VER_WORD;
      IX_HSTATE: rd_word = hstate_q;
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data     <= '0;
      soft_irq    <= 1'b0;
      hyp_tmr_irq <= 1'b0;
      illegal_acc <= 1'b0;
    end else begin
      if (rd_en) rd_data <= rd_word;
      soft_irq    <= sup_hit || set_wr;
      hyp_tmr_irq <= hyp_hit;
      illegal_acc <= bad_acc;
    end
  end

endmodule

// File: rtl/tcu_chk.sv
module tcu_chk import tcu_pkg::*; #(
  parameter int SOFT_BIT = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_en,
  input logic              wr_en,
  input logic              rd_en,
  input logic [IDX_W-1:0]  reg_idx,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              sup_hit,
  input logic              hyp_hit,
  input logic [DATA_W-1:0] softint_q,
  input logic [DATA_W-1:0] hintp_q,
  input logic [DATA_W-1:0] rd_data,
  input logic              soft_irq,
  input logic              hyp_tmr_irq,
  input logic              illegal_acc
);

  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  p_cnt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(cnt_q));

  p_sup_sets_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sup_hit |=> softint_q[SOFT_BIT] && soft_irq);

  p_hyp_pend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hyp_hit |=> (hintp_q == DATA_W'(1)) && hyp_tmr_irq);

  p_hyp_irq_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hyp_tmr_irq |-> $past(hyp_hit));

  p_base_low_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_idx == IX_HTBASE) |=> rd_data[14:0] == 15'd0);

  p_ver_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == IX_HVER) |=> illegal_acc);

  p_unimpl_rd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && reg_idx > IX_HSTATE) |=> (rd_data == '0) && illegal_acc);

endmodule

bind tmr_softint_unit tcu_chk #(.SOFT_BIT(SOFT_BIT)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cnt_en      (cnt_en),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .reg_idx     (reg_idx),
  .cnt_q       (cnt_q),
  .sup_hit     (sup_hit),
  .hyp_hit     (hyp_hit),
  .softint_q   (softint_q),
  .hintp_q     (hintp_q),
  .rd_data     (rd_data),
  .soft_irq    (soft_irq),
  .hyp_tmr_irq (hyp_tmr_irq),
  .illegal_acc (illegal_acc)
);

// File: tb/tmr_softint_unit_tb.sv
`timescale 1ns/1ps
module tmr_softint_unit_tb_top;

  typedef struct {
    logic [63:0] exp;
    string       tag;
  } rd_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] rd_data;
  logic        soft_irq, hyp_tmr_irq, illegal_acc;

  int n_chk = 0;
  int n_fail = 0;
  rd_item_t sb[$];

  localparam logic [63:0] DIS = 64'h8000_0000_0000_0000;
  localparam logic [63:0] VER = 64'h0000_0000_0003_0608;

  always #4 clk = ~clk;

  tmr_softint_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .wr_en(wr_en), .rd_en(rd_en),
    .reg_idx(reg_idx), .wr_data(wr_data), .rd_data(rd_data),
    .soft_irq(soft_irq), .hyp_tmr_irq(hyp_tmr_irq), .illegal_acc(illegal_acc)
  );

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: every read accepted at an edge is compared just after it.
  always begin
    @(posedge clk);
    if (rd_en) begin
      #2;
      if (sb.size() == 0) check(rd_data, 64'hX, "R13 unexpected read");
      else begin
        rd_item_t it;
        it = sb.pop_front();
        check(rd_data, it.exp, it.tag);
      end
    end
  end

  task automatic wr(input logic [3:0] idx, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_idx = idx; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, input logic [63:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; reg_idx = idx;
    sb.push_back('{exp: exp, tag: tag});
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  // Runs n counting edges; request expected only after edge number at_k.
  task automatic run(input int n, input int at_soft, input int at_hyp, input string tag);
    @(negedge clk);
    cnt_en = 1'b1;
    for (int k = 1; k <= n; k++) begin
      @(posedge clk); #1;
      check(64'(soft_irq), 64'(k == at_soft), {tag, " soft_irq"});
      check(64'(hyp_tmr_irq), 64'(k == at_hyp), {tag, " hyp_tmr_irq"});
    end
    @(negedge clk);
    cnt_en = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    check(64'd1, 64'd0, "watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check(rd_data, 64'd0, "R13 rd_data after reset");
    check(64'({soft_irq, hyp_tmr_irq, illegal_acc}), 64'd0, "R13 requests after reset");

    rd(4'd3, 64'd0, "R1 counter reset");
    rd(4'd4, DIS, "R2 supervisor compare reset");
    rd(4'd5, DIS, "R2 hypervisor compare reset");
    rd(4'd0, 64'd0, "R13 softint reset");
    rd(4'd6, 64'd0, "R13 pending reset");
    rd(4'd9, 64'h800, "R11 state reset");
    rd(4'd8, VER, "R10 version word");
    check(64'(illegal_acc), 64'd0, "R10 version read legal");

    wr(4'd4, 64'd5);
    wr(4'd5, 64'd5);
    rd(4'd4, 64'd5, "R2 compare readback");
    run(8, 5, 5, "R3 R4 match at count 5");
    rd(4'd3, 64'd8, "R1 counter after 8 steps");
    rd(4'd0, 64'h1_0000, "R3 softint bit 16");
    rd(4'd6, 64'd1, "R4 pending set");

    wr(4'd0, 64'hA0);
    check(64'(soft_irq), 64'd0, "R6 direct write no request");
    rd(4'd0, 64'hA0, "R6 direct write replaces");
    wr(4'd1, 64'h5);
    check(64'(soft_irq), 64'd1, "R7 set alias request");
    rd(4'd0, 64'hA5, "R7 set alias ORs");
    wr(4'd2, 64'h81);
    check(64'(soft_irq), 64'd0, "R7 clear alias no request");
    rd(4'd0, 64'h24, "R7 clear alias");
    wr(4'd6, 64'd0);
    rd(4'd6, 64'd0, "R4 pending direct clear");

    wr(4'd4, 64'd8);
    run(6, 0, 0, "R5 equal value");
    wr(4'd4, 64'd3);
    run(6, 0, 0, "R5 value behind");
    wr(4'd4, DIS | 64'd22);
    wr(4'd5, DIS | 64'd22);
    run(4, 0, 0, "R5 disabled");
    rd(4'd0, 64'h24, "R5 softint untouched");
    rd(4'd6, 64'd0, "R5 pending untouched");
    rd(4'd3, 64'd24, "R1 counter at 24");

    // R8: clear-alias write meets the supervisor match edge (25 -> 26)
    wr(4'd0, 64'h1_0005);
    wr(4'd4, 64'd26);
    @(negedge clk) cnt_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; reg_idx = 4'd2; wr_data = 64'h1_0001;
    @(posedge clk); #1;
    wr_en = 1'b0;
    check(64'(soft_irq), 64'd1, "R8 match request with clear");
    @(negedge clk) cnt_en = 1'b0;
    rd(4'd0, 64'h1_0004, "R8 match wins over clear");

    // R8: pending direct write meets the hypervisor match edge (27 -> 28)
    wr(4'd5, 64'd28);
    @(negedge clk) cnt_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b1; reg_idx = 4'd6; wr_data = 64'd0;
    @(posedge clk); #1;
    wr_en = 1'b0;
    check(64'(hyp_tmr_irq), 64'd1, "R8 hyp request with write");
    @(negedge clk) cnt_en = 1'b0;
    rd(4'd6, 64'd1, "R8 match wins over pending write");

    wr(4'd7, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(4'd7, 64'hFFFF_FFFF_FFFF_8000, "R9 base low bits");

    wr(4'd8, 64'd0);
    check(64'(illegal_acc), 64'd1, "R10 version write illegal");
    rd(4'd8, VER, "R10 version unchanged");
    check(64'(illegal_acc), 64'd0, "R10 read clears pulse");

    wr(4'd9, 64'h3);
    rd(4'd9, 64'h803, "R11 id bit forced");

    rd(4'd12, 64'd0, "R12 unimplemented read");
    check(64'(illegal_acc), 64'd1, "R12 unimplemented read pulse");
    wr(4'd13, 64'hFFFF_FFFF_FFFF_FFFF);
    check(64'(illegal_acc), 64'd1, "R12 unimplemented write pulse");
    wr(4'd3, 64'd0);
    check(64'(illegal_acc), 64'd1, "R12 counter write pulse");
    rd(4'd3, 64'd28, "R12 counter unchanged");
    rd(4'd0, 64'h1_0004, "R12 softint unchanged");
    rd(4'd7, 64'hFFFF_FFFF_FFFF_8000, "R12 base unchanged");
    @(negedge clk); #1;
    check(rd_data, 64'hFFFF_FFFF_FFFF_8000, "R13 rd_data holds");

    wait (sb.size() == 0);
    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule